// File: doc/BRIEF.md
# Dual-Port RAM with Collision Priority

A single-clock synchronous memory with two fully symmetric access ports. Each port carries its own address, write data and write strobe, and each presents a registered read word. Both ports may read or write any location on any cycle. No address range is reserved for either port.

All writes and reads are resolved inside one clocked process, so the stored contents are always well defined. When both ports write the same word on the same edge, a fixed priority picks the value that is kept. The priority is chosen by a parameter. Reads return the contents as they stood before that edge's writes. A synchronous reset clears only the two read registers and leaves the array untouched.

Top module: `dpram_prio`

## Requirements
- R1: The array holds 2**AW words of DW bits (defaults DW=16, AW=6, so 64 words), and every word can be written and read back on its own.
- R2: On a rising edge with `we0` (or `we1`) high, `wdata0` (or `wdata1`) is stored at `addr0` (or `addr1`).
- R3: On every rising edge outside reset, each port loads the word at its own address into its `rdata` register. The loaded value is visible from just after that edge.
- R4: When a port writes and reads the same address on one edge, its `rdata` shows the contents from before the write.
- R5: When one port writes an address that the other port reads on the same edge, the reading port also gets the contents from before the write.
- R6: With `P0_WINS=0` (the default), a same-edge, same-address write from both ports keeps `wdata1`.
- R7: With `P0_WINS=1`, a same-edge, same-address write from both ports keeps `wdata0`.
- R8: A rising edge with `rst` high sets both `rdata0` and `rdata1` to zero. It does not alter stored words.
- R9: Writes to one address on consecutive edges leave the later value stored.
- R10: Either port may write any address, and a word written by one port is read back correctly by the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all activity on rising edge |
| rst | input | 1 | Synchronous active-high reset of the read registers |
| addr0 | input | AW | Port 0 word address |
| wdata0 | input | DW | Port 0 write data |
| we0 | input | 1 | Port 0 write strobe |
| rdata0 | output | DW | Port 0 registered read word |
| addr1 | input | AW | Port 1 word address |
| wdata1 | input | DW | Port 1 write data |
| we1 | input | 1 | Port 1 write strobe |
| rdata1 | output | DW | Port 1 registered read word |

## Verification
The bench builds two copies of the block with the default 16-bit by 64-word geometry. Both copies receive the same stimulus. One copy uses `P0_WINS=0` and the other uses `P0_WINS=1`, so a single colliding write shows both priority outcomes side by side. The default depth is small enough for the bench to fill and read back every address, including the top word 63. The stimulus also covers same-port and cross-port read-before-write, back-to-back writes, and a reset applied over stored data.

// File: rtl/dpram_prio.sv
module dpram_prio #(
  parameter int DW      = 16,
  parameter int AW      = 6,
  parameter bit P0_WINS = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr0,
  input  logic [DW-1:0] wdata0,
  input  logic          we0,
  output logic [DW-1:0] rdata0,
  input  logic [AW-1:0] addr1,
  input  logic [DW-1:0] wdata1,
  input  logic          we1,
  output logic [DW-1:0] rdata1
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Single process: the later non-blocking write wins, so order encodes priority.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata0 <= '0;
      rdata1 <= '0;
    end else begin
      rdata0 <= mem[addr0];
      rdata1 <= mem[addr1];
    end
    if (P0_WINS) begin
      if (we1) mem[addr1] <= wdata1;
      if (we0) mem[addr0] <= wdata0;
    end else begin
      if (we0) mem[addr0] <= wdata0;
      if (we1) mem[addr1] <= wdata1;
    end
  end

  wire same_addr = (addr0 == addr1);

  // R8: reset clears both read registers
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (rdata0 == '0 && rdata1 == '0));

  // R4, R9: a lone port-0 write is returned to port 0 one edge later,
  // even if port 0 writes the same word again on that edge
  a_r4_own_old_then_new: assert property (@(posedge clk) disable iff (rst)
    ($past(we0 && !(we1 && same_addr)) && addr0 == $past(addr0))
    |=> rdata0 == $past(wdata0, 2));

  // R5, R10: a lone port-0 write is seen by port 1 on the following read
  a_r10_cross_port: assert property (@(posedge clk) disable iff (rst)
    ($past(we0 && !(we1 && same_addr)) && addr1 == $past(addr0))
    |=> rdata1 == $past(wdata0, 2));

  // R6 and R7: colliding writes keep the data of the priority port
  a_r6_collision_winner: assert property (@(posedge clk) disable iff (rst)
    ($past(we0 && we1 && same_addr) && addr0 == $past(addr0))
    |=> rdata0 == (P0_WINS ? $past(wdata0, 2) : $past(wdata1, 2)));

endmodule

// File: tb/dpram_prio_tb.sv
module dpram_prio_tb;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr0 = '0, addr1 = '0;
  logic [DW-1:0] wdata0 = '0, wdata1 = '0;
  logic we0 = 1'b0, we1 = 1'b0;
  logic [DW-1:0] rdata0, rdata1, prd0, prd1;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  dpram_prio #(.DW(DW), .AW(AW), .P0_WINS(1'b0)) u_dut (
    .clk(clk), .rst(rst),
    .addr0(addr0), .wdata0(wdata0), .we0(we0), .rdata0(rdata0),
    .addr1(addr1), .wdata1(wdata1), .we1(we1), .rdata1(rdata1));

  dpram_prio #(.DW(DW), .AW(AW), .P0_WINS(1'b1)) u_dut_p0 (
    .clk(clk), .rst(rst),
    .addr0(addr0), .wdata0(wdata0), .we0(we0), .rdata0(prd0),
    .addr1(addr1), .wdata1(wdata1), .we1(we1), .rdata1(prd1));

  typedef struct packed {
    logic          w0; logic [AW-1:0] a0; logic [DW-1:0] d0;
    logic          w1; logic [AW-1:0] a1; logic [DW-1:0] d1;
    logic          c0; logic [DW-1:0] e0;
    logic          c1; logic [DW-1:0] e1;
    logic          cp; logic [DW-1:0] ep;
  } vec_t;

  // Expected values are the read results just after the row's edge.
  localparam vec_t TBL [9] = '{
    '{1'b1, 6'd5,  16'h1111, 1'b1, 6'd9,  16'h2222, 1'b0, 16'h0,    1'b0, 16'h0,    1'b0, 16'h0},
    '{1'b1, 6'd5,  16'h3333, 1'b0, 6'd5,  16'h0,    1'b1, 16'h1111, 1'b1, 16'h1111, 1'b0, 16'h0},
    '{1'b0, 6'd5,  16'h0,    1'b0, 6'd9,  16'h0,    1'b1, 16'h3333, 1'b1, 16'h2222, 1'b0, 16'h0},
    '{1'b1, 6'd7,  16'h0AAA, 1'b1, 6'd7,  16'h0BBB, 1'b0, 16'h0,    1'b0, 16'h0,    1'b0, 16'h0},
    '{1'b0, 6'd7,  16'h0,    1'b0, 6'd7,  16'h0,    1'b1, 16'h0BBB, 1'b1, 16'h0BBB, 1'b1, 16'h0AAA},
    '{1'b1, 6'd9,  16'hC0C0, 1'b0, 6'd9,  16'h0,    1'b1, 16'h2222, 1'b1, 16'h2222, 1'b0, 16'h0},
    '{1'b0, 6'd9,  16'h0,    1'b0, 6'd5,  16'h0,    1'b1, 16'hC0C0, 1'b1, 16'h3333, 1'b0, 16'h0},
    '{1'b0, 6'd5,  16'h0,    1'b1, 6'd63, 16'hFFFF, 1'b1, 16'h3333, 1'b0, 16'h0,    1'b0, 16'h0},
    '{1'b0, 6'd63, 16'h0,    1'b0, 6'd0,  16'h0,    1'b1, 16'hFFFF, 1'b0, 16'h0,    1'b0, 16'h0}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    step();
    step();
    check("R8 reset rdata0", rdata0, '0);
    check("R8 reset rdata1", rdata1, '0);
    check("R8 reset p0 rdata0", prd0, '0);
    rst = 1'b0;

    foreach (TBL[i]) begin
      we0 = TBL[i].w0; addr0 = TBL[i].a0; wdata0 = TBL[i].d0;
      we1 = TBL[i].w1; addr1 = TBL[i].a1; wdata1 = TBL[i].d1;
      step();
      // rows cover R2 R3 R4 R5 R6 R7 R9 R10
      if (TBL[i].c0) check($sformatf("R4/R6/R9 row %0d port0", i), rdata0, TBL[i].e0);
      if (TBL[i].c1) check($sformatf("R5/R10 row %0d port1", i), rdata1, TBL[i].e1);
      if (TBL[i].cp) check($sformatf("R7 row %0d p0 priority", i), prd0, TBL[i].ep);
    end

    // R1: fill every word through port 0, read back through port 1
    we1 = 1'b0;
    for (int a = 0; a < DEPTH; a++) begin
      we0 = 1'b1; addr0 = AW'(a); wdata0 = DW'(a * 16'h0101 + 16'h0040);
      step();
    end
    we0 = 1'b0;
    for (int a = 0; a < DEPTH; a++) begin
      addr1 = AW'(a);
      step();
      check($sformatf("R1 word %0d", a), rdata1, DW'(a * 16'h0101 + 16'h0040));
    end

    // R8: reset zeroes outputs but keeps stored words
    addr0 = 6'd12; addr1 = 6'd63;
    rst = 1'b1;
    step();
    check("R8 rst rdata0", rdata0, '0);
    check("R8 rst rdata1", rdata1, '0);
    rst = 1'b0;
    step();
    check("R8 kept word 12", rdata0, DW'(12 * 16'h0101 + 16'h0040));
    check("R8 kept word 63", rdata1, DW'(63 * 16'h0101 + 16'h0040));

    // R6/R7 second collision at address 0, then port 1 reads it
    we0 = 1'b1; we1 = 1'b1; addr0 = 6'd0; addr1 = 6'd0;
    wdata0 = 16'h5A5A; wdata1 = 16'hA5A5;
    step();
    we0 = 1'b0; we1 = 1'b0;
    step();
    check("R6 collision port1 kept", rdata1, 16'hA5A5);
    check("R7 collision port0 kept", prd1, 16'h5A5A);

    done = 1'b1;
    finish_run();
  end
endmodule